// File: doc/BRIEF.md
# Selectable-Rate Periodic Interrupt Timer

This block raises a periodic timeout at one of four rates and records each timeout in a sticky status flag. The four periods come from taps of one free-running binary divider. A two-bit rate select input picks the tap. A separate enable input decides whether a set flag also drives the interrupt request output. Software clears the flag by writing a 1 to its bit position in the status register write port.

The divider starts from zero when reset is released. Because of this, the first flag of any rate arrives only after one whole period of that rate. A change of rate does not restart the divider. The next timeout therefore falls on the next wrap of the newly chosen tap, measured on the same time base.

Top module: `pit_timer`

## Requirements
- R1: With `rate_sel` = k (k = 0..3), successive timeouts are exactly 2^(BASE_LOG2+k) clock cycles apart. The default BASE_LOG2 is 13, which gives 8192, 16384, 32768 and 65536 cycles.
- R2: After reset is released, the flag first reads 1 exactly one full period of the selected rate later: after 2^(BASE_LOG2+k) rising edges, and not earlier.
- R3: Every timeout sets `flag_o`, whatever the value of `int_en`.
- R4: `irq_o` is registered. After each edge it equals the new flag value ANDed with the `int_en` value sampled at that edge, so `irq_o` is never 1 while `flag_o` is 0.
- R5: A cycle with `flag_wr` = 1 and bit FLAG_BIT of `flag_wdata` = 1 (default bit 6) clears the flag at the next edge. Writing 0 to that bit, or presenting data without `flag_wr`, leaves the flag unchanged.
- R6: When a timeout and a clearing write fall on the same edge, the flag ends set.
- R7: Changing `rate_sel` does not reset the divider. The next timeout comes when the count since reset next reaches a multiple of the new period.
- R8: While `rst` is high, `flag_o` and `irq_o` are 0, and the internal rate register holds 00.
- R9: Once set, the flag stays set across later timeouts until a clearing write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Timeout rate select, registered inside the block |
| int_en | input | 1 | Interrupt enable |
| flag_wr | input | 1 | Write strobe for the status register |
| flag_wdata | input | REG_W | Status register write data; bit FLAG_BIT = 1 clears the flag |
| flag_o | output | 1 | Sticky timeout flag readback |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted divider count does not show at once. It appears only as a timeout on `flag_o` that comes early or late against the count of edges since reset, and a full period of the selected rate can pass before the error is visible. For that reason the bench times flag rises against its own edge count since reset, both after reset and after switches between rates. A wrong flag or interrupt register shows at the next edge. The bench therefore reads `flag_o` and `irq_o` one cycle after each write, each enable change and each coincident clear.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int NUM_RATES = 4;
  localparam int RATE_W    = $clog2(NUM_RATES);
  typedef logic [RATE_W-1:0] rate_t;
  localparam rate_t RATE_RESET = '0;
endpackage

// File: rtl/pit_divider.sv
module pit_divider #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  // The divider never restarts on a rate change: it only steps by one.
  p_free_run_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> count_q == $past(count_q) + 1'b1);
endmodule

// File: rtl/pit_tap_select.sv
module pit_tap_select
  import pit_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter int CNT_W     = BASE_LOG2 + NUM_RATES - 1
) (
  input  logic [CNT_W-1:0] count_i,
  input  rate_t            rate_i,
  output logic             tick_o
);
  logic [NUM_RATES-1:0] tap_wrap;

  for (genvar k = 0; k < NUM_RATES; k++) begin : g_tap
    localparam int TAP_W = BASE_LOG2 + k;
    assign tap_wrap[k] = &count_i[TAP_W-1:0];
  end

  assign tick_o = tap_wrap[rate_i];
endmodule

// File: rtl/pit_flag.sv
module pit_flag #(
  parameter int REG_W    = 8,
  parameter int FLAG_BIT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             int_en_i,
  output logic             flag_o,
  output logic             irq_o
);
  logic flag_q, irq_q;
  logic clear_req, flag_next;

  assign clear_req = wr_i & wdata_i[FLAG_BIT];
  assign flag_next = tick_i | (flag_q & ~clear_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_next;
      irq_q  <= flag_next & int_en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> flag_q);
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clear_req && !tick_i) |=> !flag_q);
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clear_req) |=> flag_q);
  p_rise_from_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !tick_i) |=> !flag_q);
  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
  p_irq_enable_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && int_en_i) |=> irq_q);
  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> !tick_i);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter int REG_W     = 8,
  parameter int FLAG_BIT  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rate_sel,
  input  logic             int_en,
  input  logic             flag_wr,
  input  logic [REG_W-1:0] flag_wdata,
  output logic             flag_o,
  output logic             irq_o
);
  localparam int CNT_W = BASE_LOG2 + NUM_RATES - 1;

  rate_t            rate_q;
  logic [CNT_W-1:0] div_count;
  logic             tick;

  always_ff @(posedge clk) begin
    if (rst) rate_q <= RATE_RESET;
    else     rate_q <= rate_t'(rate_sel);
  end

  p_rate_reset_r8: assert property (@(posedge clk)
    $past(rst) |-> rate_q == RATE_RESET);

  pit_divider #(.CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .count_o (div_count)
  );

  pit_tap_select #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_tap (
    .count_i (div_count),
    .rate_i  (rate_q),
    .tick_o  (tick)
  );

  pit_flag #(.REG_W(REG_W), .FLAG_BIT(FLAG_BIT)) u_flag (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .wr_i     (flag_wr),
    .wdata_i  (flag_wdata),
    .int_en_i (int_en),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );
endmodule

// File: tb/pit_timer_bench.sv
module pit_timer_bench;
  localparam int B   = 5;
  localparam int RW  = 8;
  localparam int FB  = 6;
  localparam int P3  = 1 << (B + 3);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    rate_sel = 2'd0;
  logic          int_en = 1'b0;
  logic          flag_wr = 1'b0;
  logic [RW-1:0] flag_wdata = '0;
  logic          flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rel_cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pit_timer #(.BASE_LOG2(B), .REG_W(RW), .FLAG_BIT(FB)) u_pit_timer (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .int_en(int_en),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  function automatic int edges();
    return cyc - rel_cyc;
  endfunction

  function automatic int period(input int r);
    return 1 << (B + r);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] r);
    @(negedge clk);
    rst = 1'b1; rate_sel = r; flag_wr = 1'b0; int_en = 1'b0;
    repeat (3) @(negedge clk);
    check(flag_o == 1'b0, "R8", "flag in reset", flag_o, 0);
    check(irq_o == 1'b0, "R8", "irq in reset", irq_o, 0);
    rst = 1'b0;
    rel_cyc = cyc;
  endtask

  task automatic wait_flag(output int at);
    int n = 0;
    while (flag_o !== 1'b1 && n < 2 * P3) begin
      @(negedge clk);
      n++;
    end
    at = edges();
  endtask

  task automatic clear_flag();
    flag_wr = 1'b1; flag_wdata = RW'(1 << FB);
    @(negedge clk);
    flag_wr = 1'b0; flag_wdata = '0;
  endtask

  task automatic wait_until_mod(input int m, input int v);
    int n = 0;
    while ((edges() % m) != v && n < 2 * P3) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_first_period(input int r);
    do_reset(2'(r));
    repeat (period(r) - 1) @(negedge clk);
    check(flag_o == 1'b0, "R2", "flag one edge before first period", flag_o, 0);
    @(negedge clk);
    check(flag_o == 1'b1, "R2", "flag at first period", flag_o, 1);
  endtask

  task automatic t_rates();
    int a, b;
    for (int r = 0; r < 4; r++) begin
      rate_sel = 2'(r);
      wait_flag(a);
      clear_flag();
      wait_flag(a);
      clear_flag();
      wait_flag(b);
      check(b - a == period(r), "R1", "timeout spacing", b - a, period(r));
      clear_flag();
    end
  endtask

  task automatic t_irq();
    int t;
    rate_sel = 2'd0; int_en = 1'b0;
    clear_flag();
    wait_flag(t);
    check(flag_o == 1'b1, "R3", "flag set with irq disabled", flag_o, 1);
    check(irq_o == 1'b0, "R4", "irq low while disabled", irq_o, 0);
    int_en = 1'b1;
    @(negedge clk);
    check(irq_o == 1'b1, "R4", "irq after enable", irq_o, 1);
    int_en = 1'b0;
    @(negedge clk);
    check(irq_o == 1'b0, "R4", "irq after disable", irq_o, 0);
    check(flag_o == 1'b1, "R3", "flag kept after disable", flag_o, 1);
    int_en = 1'b1;
    @(negedge clk);
    clear_flag();
    check(flag_o == 1'b0, "R5", "flag after clear", flag_o, 0);
    check(irq_o == 1'b0, "R4", "irq after clear", irq_o, 0);
    int_en = 1'b0;
  endtask

  task automatic t_writes();
    int t;
    rate_sel = 2'd0;
    wait_flag(t);
    flag_wr = 1'b1; flag_wdata = ~RW'(1 << FB);
    @(negedge clk);
    flag_wr = 1'b0;
    check(flag_o == 1'b1, "R5", "zero write to flag bit", flag_o, 1);
    flag_wdata = RW'(1 << FB);
    @(negedge clk);
    flag_wdata = '0;
    check(flag_o == 1'b1, "R5", "data without strobe", flag_o, 1);
    repeat (2 * period(0)) @(negedge clk);
    check(flag_o == 1'b1, "R9", "flag sticky over timeouts", flag_o, 1);
    clear_flag();
    check(flag_o == 1'b0, "R5", "clearing write", flag_o, 0);
  endtask

  task automatic t_set_wins();
    int t, n;
    rate_sel = 2'd0;
    @(negedge clk);
    clear_flag();
    wait_flag(t);
    clear_flag();
    n = 0;
    while (edges() != t + period(0) - 1 && n < P3) begin
      @(negedge clk);
      n++;
    end
    check(flag_o == 1'b0, "R6", "flag before coincident edge", flag_o, 0);
    flag_wr = 1'b1; flag_wdata = RW'(1 << FB);
    @(negedge clk);
    flag_wr = 1'b0; flag_wdata = '0;
    check(flag_o == 1'b1, "R6", "timeout beats clear", flag_o, 1);
  endtask

  task automatic t_rate_change();
    // Slow to fast: switch 3 -> 0 at count 99 (mod 256); next set at 128.
    rate_sel = 2'd3;
    wait_until_mod(P3, 98);
    clear_flag();
    rate_sel = 2'd0;
    repeat (127 - 99) @(negedge clk);
    check(flag_o == 1'b0, "R7", "no set before new tap wrap", flag_o, 0);
    @(negedge clk);
    check(flag_o == 1'b1, "R7", "set on new tap wrap", flag_o, 1);
    check((edges() % P3) == 128, "R7", "wrap position", edges() % P3, 128);
    // Fast to slow: switch 0 -> 2 at count 34 (mod 256); next set at 128.
    wait_until_mod(P3, 33);
    clear_flag();
    rate_sel = 2'd2;
    repeat (127 - 34) @(negedge clk);
    check(flag_o == 1'b0, "R7", "no rate-0 tick after switch", flag_o, 0);
    @(negedge clk);
    check(flag_o == 1'b1, "R7", "set at rate-2 wrap", flag_o, 1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    t_first_period(0);
    t_first_period(1);
    t_first_period(3);
    t_rates();
    t_irq();
    t_writes();
    t_set_wins();
    do_reset(2'd0);
    t_rate_change();
    finish_run();
  end
endmodule